// File: doc/BRIEF.md
# SPI Playback Command Decoder

This block sits behind the serial slave port of a voice record/playback controller and recognises the direct-access "play a range" command. While the slave select line is low, it shifts in a fixed seven-byte frame on MOSI. The frame carries an opcode, two address fields of `ADDR_W` bits each and fixed filler. When the frame ends, the block checks it. A good frame either starts playback or, if playback is already running, queues the address pair as the next segment. A bad frame produces a one-cycle error pulse and changes nothing.

At the same time the block returns a 16-bit status word on MISO, low byte and then high byte, repeating for as long as the frame lasts. Two bits of that word are owned here: a busy-playing flag and a ready flag. The other fourteen bits come from outside. The playback engine reports the end of each segment with `play_done`. The block answers with an interrupt pulse. It then either moves on to the queued segment or goes back to idle.

All serial pins are asynchronous to `clk` and are brought in through a synchroniser of `SYNC_STAGES` flops. The serial clock must therefore be slow compared with `clk`.

Top module: `spi_play_cmd_decoder`

## Requirements
- R1: After reset `play_busy` is 0, `ready` is 1, and `start_req`, `preload_req`, `frame_err` and `irq` are 0.
- R2: MOSI is sampled on rising serial clock edges, least significant bit of each byte first. The bytes of a frame, in order, are: 0x80, 0x00, start[7:0], {zeros, start[ADDR_W-1:8]}, end[7:0], {zeros, end[ADDR_W-1:8]}, 0x00. For a valid frame, `start_addr`/`end_addr` show the two decoded fields while the request pulse is high.
- R3: A frame whose opcode byte is not 0x80, or whose second or seventh byte is not 0x00, gives one `frame_err` pulse and no request.
- R4: A frame with any nonzero filler bit above an address field gives one `frame_err` pulse and no request.
- R5: A frame with fewer or more than 56 serial clock rising edges before select rises gives one `frame_err` pulse and no request.
- R6: MISO presents bit 0 of the status word before the first rising edge and advances on each falling edge. It sends bits [7:0] then [15:8], LSB first, repeating. The word is `status_ext` with bit 0 replaced by `ready` and bit 1 by `play_busy`, captured when select falls.
- R7: A valid frame received while idle gives one `start_req` pulse, with `play_busy` 1 and `ready` 0 from that cycle on.
- R8: A valid frame received while playing gives one `preload_req` pulse, not `start_req`, and `play_busy` stays 1.
- R9: `play_done` while playing gives one `irq` pulse on the next cycle. With a segment queued, `play_busy` stays 1 and the queued segment is used up. With nothing queued, `play_busy` drops to 0 and `ready` rises.
- R10: `start_req`, `preload_req` and `frame_err` are single-cycle pulses and never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock, idle low |
| spi_cs_n | input | 1 | Slave select, active low |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial status out, 0 while deselected |
| status_ext | input | 16 | Status word bits supplied by other logic (bits 1:0 ignored) |
| play_done | input | 1 | Current playback segment finished |
| start_addr | output | ADDR_W | Decoded start address |
| end_addr | output | ADDR_W | Decoded end address |
| start_req | output | 1 | Pulse: begin playback at the decoded range |
| preload_req | output | 1 | Pulse: decoded range queued as next segment |
| frame_err | output | 1 | Pulse: frame rejected |
| play_busy | output | 1 | Playback in progress |
| ready | output | 1 | Device ready for a new operation |
| irq | output | 1 | Pulse: a segment completed |

## Verification
The bench sends frames one bit short and one byte long. A decoder that only tests the count at some threshold would accept these and issue a request. It sets a single filler bit, which a decoder that masks the padding would let through as a wider address. It also sends a wrapped range, end below start, which must pass through untouched. It sends a second good frame during playback, which a decoder that ignored the busy state would turn into a restart instead of a queue entry. It then completes two segments and checks that the first keeps playback running and the second ends it. The MISO stream is compared on every frame against the word the bench expects. This catches a swapped byte order, MSB-first output, and a play/ready snapshot taken at the wrong time.

// File: rtl/spi_play_pkg.sv
package spi_play_pkg;

   localparam int unsigned FRAME_BYTES = 7;
   localparam int unsigned FRAME_BITS  = FRAME_BYTES * 8;
   localparam logic [7:0]  OPCODE_PLAY = 8'h80;

   // status word positions owned by this block
   localparam int unsigned READY_POS = 0;
   localparam int unsigned PLAY_POS  = 1;

   typedef enum logic [1:0] {
      EV_NONE  = 2'd0,
      EV_START = 2'd1,
      EV_QUEUE = 2'd2,
      EV_ERROR = 2'd3
   } play_ev_e;

endpackage

// File: rtl/spi_play_sync.sv
module spi_play_sync #(
   parameter int unsigned WIDTH       = 3,
   parameter int unsigned STAGES      = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q_sync
);

   logic [WIDTH-1:0] chain [STAGES];

   generate
      if (STAGES < 2) begin : g_bad
         $error("spi_play_sync: STAGES must be at least 2");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               chain[s] <= RST_VAL;
            else if (s == 0)
               chain[s] <= d_async;
            else
               chain[s] <= chain[(s == 0) ? 0 : s - 1];
         end
      end
   endgenerate

   assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/spi_play_frame_rx.sv
module spi_play_frame_rx
   import spi_play_pkg::*;
#(
   parameter int unsigned ADDR_W = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sck_rise,
   input  logic              sel_fall,
   input  logic              sel_rise,
   input  logic              mosi_bit,
   output logic              cmd_ok,
   output logic              cmd_bad,
   output logic [ADDR_W-1:0] cmd_start,
   output logic [ADDR_W-1:0] cmd_end
);

   localparam int unsigned HI_W  = ADDR_W - 8;
   localparam int unsigned CNT_W = $clog2(FRAME_BITS + 2);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
   localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_BITS + 1);

   logic [FRAME_BITS-1:0] shreg;
   logic [CNT_W-1:0]      bit_cnt;
   logic [7:0]            byte_v [FRAME_BYTES];
   logic                  frame_good;

   // first bit received ends in bit 0 after a full frame
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg   <= '0;
         bit_cnt <= '0;
      end else if (sel_fall) begin
         bit_cnt <= '0;
      end else if (sck_rise) begin
         shreg <= {mosi_bit, shreg[FRAME_BITS-1:1]};
         if (bit_cnt != CNT_OVER)
            bit_cnt <= bit_cnt + 1'b1;
      end
   end

   generate
      for (genvar b = 0; b < FRAME_BYTES; b++) begin : g_byte
         assign byte_v[b] = shreg[8*b +: 8];
      end
   endgenerate

   always_comb begin
      frame_good = (bit_cnt == CNT_FULL)
                 && (byte_v[0] == OPCODE_PLAY)
                 && (byte_v[1] == 8'h00)
                 && ((byte_v[3] >> HI_W) == 8'h00)
                 && ((byte_v[5] >> HI_W) == 8'h00)
                 && (byte_v[6] == 8'h00);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_ok    <= 1'b0;
         cmd_bad   <= 1'b0;
         cmd_start <= '0;
         cmd_end   <= '0;
      end else begin
         cmd_ok  <= sel_rise && frame_good;
         cmd_bad <= sel_rise && !frame_good;
         if (sel_rise && frame_good) begin
            cmd_start <= {byte_v[3][HI_W-1:0], byte_v[2]};
            cmd_end   <= {byte_v[5][HI_W-1:0], byte_v[4]};
         end
      end
   end

endmodule

// File: rtl/spi_play_status_tx.sv
module spi_play_status_tx #(
   parameter int unsigned WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_active,
   input  logic              sel_fall,
   input  logic              sck_fall,
   input  logic [WORD_W-1:0] word_in,
   output logic              miso
);

   localparam int unsigned NBYTES = WORD_W / 8;
   localparam int unsigned IDX_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1;

   logic [WORD_W-1:0] snap;
   logic [7:0]        txb;
   logic [2:0]        bit_idx;
   logic [IDX_W-1:0]  next_byte;
   logic [IDX_W-1:0]  after_next;

   generate
      if (WORD_W % 8 != 0 || WORD_W < 8) begin : g_bad
         $error("spi_play_status_tx: WORD_W must be a multiple of 8");
      end
   endgenerate

   always_comb begin
      if (32'(next_byte) == NBYTES - 1)
         after_next = '0;
      else
         after_next = next_byte + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         snap      <= '0;
         txb       <= '0;
         bit_idx   <= '0;
         next_byte <= '0;
      end else if (sel_fall) begin
         snap      <= word_in;
         txb       <= word_in[7:0];
         bit_idx   <= '0;
         next_byte <= (NBYTES > 1) ? IDX_W'(1) : '0;
      end else if (sel_active && sck_fall) begin
         if (bit_idx == 3'd7) begin
            txb       <= snap[8*next_byte +: 8];
            next_byte <= after_next;
            bit_idx   <= '0;
         end else begin
            txb     <= {1'b0, txb[7:1]};
            bit_idx <= bit_idx + 1'b1;
         end
      end
   end

   assign miso = sel_active & txb[0];

endmodule

// File: rtl/spi_play_ctrl.sv
module spi_play_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic cmd_ok,
   input  logic play_done,
   output logic start_req,
   output logic preload_req,
   output logic play_busy,
   output logic irq
);

   logic pending;
   logic play_n, pend_n, start_n, queue_n, irq_n;

   always_comb begin
      play_n  = play_busy;
      pend_n  = pending;
      start_n = 1'b0;
      queue_n = 1'b0;
      irq_n   = 1'b0;
      if (play_done && play_busy) begin
         irq_n = 1'b1;
         if (pending) pend_n = 1'b0;
         else         play_n = 1'b0;
      end
      if (cmd_ok) begin
         if (play_n) begin
            queue_n = 1'b1;
            pend_n  = 1'b1;
         end else begin
            start_n = 1'b1;
            play_n  = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         play_busy   <= 1'b0;
         pending     <= 1'b0;
         start_req   <= 1'b0;
         preload_req <= 1'b0;
         irq         <= 1'b0;
      end else begin
         play_busy   <= play_n;
         pending     <= pend_n;
         start_req   <= start_n;
         preload_req <= queue_n;
         irq         <= irq_n;
      end
   end

endmodule

// File: rtl/spi_play_cmd_decoder.sv
module spi_play_cmd_decoder
   import spi_play_pkg::*;
#(
   parameter int unsigned ADDR_W      = 11,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spi_sck,
   input  logic              spi_cs_n,
   input  logic              spi_mosi,
   output logic              spi_miso,
   input  logic [15:0]       status_ext,
   input  logic              play_done,
   output logic [ADDR_W-1:0] start_addr,
   output logic [ADDR_W-1:0] end_addr,
   output logic              start_req,
   output logic              preload_req,
   output logic              frame_err,
   output logic              play_busy,
   output logic              ready,
   output logic              irq
);

   localparam int unsigned STATUS_W = 16;

   generate
      if (ADDR_W < 9 || ADDR_W > 16) begin : g_bad_addr
         $error("spi_play_cmd_decoder: ADDR_W must lie in 9..16");
      end
   endgenerate

   logic [2:0] pins_s;
   logic       sck_s, sel_n_s, mosi_s;
   logic       sck_q, sel_n_q;
   logic       sck_rise, sck_fall, sel_fall, sel_rise;
   logic       cmd_ok;
   logic [STATUS_W-1:0] word_now;

   spi_play_sync #(
      .WIDTH   (3),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (3'b010)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async ({spi_mosi, spi_cs_n, spi_sck}),
      .q_sync  (pins_s)
   );

   assign sck_s   = pins_s[0];
   assign sel_n_s = pins_s[1];
   assign mosi_s  = pins_s[2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_q   <= 1'b0;
         sel_n_q <= 1'b1;
      end else begin
         sck_q   <= sck_s;
         sel_n_q <= sel_n_s;
      end
   end

   assign sck_rise = !sel_n_s &&  sck_s && !sck_q;
   assign sck_fall = !sel_n_s && !sck_s &&  sck_q;
   assign sel_fall = !sel_n_s &&  sel_n_q;
   assign sel_rise =  sel_n_s && !sel_n_q;

   spi_play_frame_rx #(
      .ADDR_W (ADDR_W)
   ) u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .sck_rise  (sck_rise),
      .sel_fall  (sel_fall),
      .sel_rise  (sel_rise),
      .mosi_bit  (mosi_s),
      .cmd_ok    (cmd_ok),
      .cmd_bad   (frame_err),
      .cmd_start (start_addr),
      .cmd_end   (end_addr)
   );

   always_comb begin
      word_now            = status_ext;
      word_now[READY_POS] = ready;
      word_now[PLAY_POS]  = play_busy;
   end

   spi_play_status_tx #(
      .WORD_W (STATUS_W)
   ) u_tx (
      .clk        (clk),
      .rst_n      (rst_n),
      .sel_active (!sel_n_s),
      .sel_fall   (sel_fall),
      .sck_fall   (sck_fall),
      .word_in    (word_now),
      .miso       (spi_miso)
   );

   spi_play_ctrl u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .cmd_ok      (cmd_ok),
      .play_done   (play_done),
      .start_req   (start_req),
      .preload_req (preload_req),
      .play_busy   (play_busy),
      .irq         (irq)
   );

   assign ready = !play_busy;

endmodule

// File: rtl/spi_play_cmd_decoder_chk.sv
module spi_play_cmd_decoder_chk (
   input logic clk,
   input logic rst_n,
   input logic start_req,
   input logic preload_req,
   input logic frame_err,
   input logic play_busy,
   input logic ready,
   input logic irq
);

   assert_pulses_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({start_req, preload_req, frame_err}));

   assert_start_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      start_req |=> !start_req);

   assert_err_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      frame_err |=> !frame_err);

   assert_start_enters_play_R7: assert property (@(posedge clk) disable iff (!rst_n)
      start_req |-> (play_busy && !ready));

   assert_start_from_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      start_req |-> !$past(play_busy));

   assert_preload_when_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      preload_req |-> ($past(play_busy) && play_busy));

   assert_irq_from_play_R9: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $past(play_busy));

   assert_stop_raises_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(play_busy) |-> irq);

endmodule

bind spi_play_cmd_decoder spi_play_cmd_decoder_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start_req   (start_req),
   .preload_req (preload_req),
   .frame_err   (frame_err),
   .play_busy   (play_busy),
   .ready       (ready),
   .irq         (irq)
);

// File: tb/spi_play_cmd_decoder_bench.sv
module spi_play_cmd_decoder_bench;

   localparam int CLK_PERIOD = 10;
   localparam int HALF       = 8;
   localparam int AW         = 11;

   typedef struct packed {
      logic [1:0]    kind;   // 1 start, 2 queue, 3 error
      logic [AW-1:0] s;
      logic [AW-1:0] e;
   } ev_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic spi_sck = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
   logic spi_miso;
   logic [15:0] status_ext = 16'h0000;
   logic play_done = 1'b0;
   logic [AW-1:0] start_addr, end_addr;
   logic start_req, preload_req, frame_err, play_busy, ready, irq;

   int checks = 0;
   int errors = 0;
   ev_t exp_q[$];
   bit exp_play = 1'b0;
   bit exp_pend = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   spi_play_cmd_decoder #(.ADDR_W(AW), .SYNC_STAGES(2)) u_spi_play_cmd_decoder (
      .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
      .spi_mosi(spi_mosi), .spi_miso(spi_miso), .status_ext(status_ext),
      .play_done(play_done), .start_addr(start_addr), .end_addr(end_addr),
      .start_req(start_req), .preload_req(preload_req), .frame_err(frame_err),
      .play_busy(play_busy), .ready(ready), .irq(irq)
   );

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // monitor: pops the scoreboard whenever a result pulse appears
   always @(negedge clk) begin
      if (rst_n && (start_req || preload_req || frame_err)) begin
         logic [1:0] k;
         k = start_req ? 2'd1 : (preload_req ? 2'd2 : 2'd3);
         if (exp_q.size() == 0) begin
            check(1'b0, "R10 unexpected pulse", {62'd0, k}, 64'd0);
         end else begin
            ev_t x;
            x = exp_q.pop_front();
            check(k == x.kind, "R3/R4/R5/R7/R8 event kind", {62'd0, k}, {62'd0, x.kind});
            if (x.kind != 2'd3)
               check(start_addr == x.s && end_addr == x.e, "R2 decoded addresses",
                     {start_addr, end_addr}, {x.s, x.e});
         end
      end
   end

   function automatic logic [63:0] mk_frame(input logic [7:0] op, input logic [7:0] b1,
                                            input logic [AW-1:0] s, input logic [AW-1:0] e,
                                            input logic [4:0] pad_s, input logic [7:0] tail);
      logic [63:0] f;
      f = '0;
      f[7:0]   = op;
      f[15:8]  = b1;
      f[23:16] = s[7:0];
      f[31:24] = {pad_s, s[10:8]};
      f[39:32] = e[7:0];
      f[47:40] = {5'b0, e[10:8]};
      f[55:48] = tail;
      return f;
   endfunction

   // driver: pushes the expected result, then clocks the frame out
   task automatic send_frame(input logic [63:0] bits, input int n, input bit good,
                             input logic [AW-1:0] s, input logic [AW-1:0] e);
      logic [15:0] word;
      logic [63:0] got, want;
      ev_t x;
      word = {status_ext[15:2], exp_play, ~exp_play};
      if (good) begin
         x.kind = exp_play ? 2'd2 : 2'd1;
         if (exp_play) exp_pend = 1'b1;
         exp_play = 1'b1;
      end else
         x.kind = 2'd3;
      x.s = s; x.e = e;
      exp_q.push_back(x);
      got = '0; want = '0;
      @(negedge clk);
      spi_cs_n = 1'b0;
      repeat (HALF) @(negedge clk);
      for (int i = 0; i < n; i++) begin
         spi_mosi = bits[i];
         repeat (HALF) @(negedge clk);
         got[i]  = spi_miso;
         want[i] = word[((i / 8) % 2) * 8 + (i % 8)];
         spi_sck = 1'b1;
         repeat (HALF) @(negedge clk);
         spi_sck = 1'b0;
      end
      repeat (HALF) @(negedge clk);
      spi_cs_n = 1'b1;
      repeat (4 * HALF) @(negedge clk);
      check(got == want, "R6 MISO status stream", got, want);
      check(play_busy == exp_play && ready == !exp_play, "R7/R8 play and ready state",
            {62'd0, play_busy, ready}, {62'd0, exp_play, !exp_play});
   endtask

   task automatic finish_segment();
      @(negedge clk);
      play_done = 1'b1;
      @(negedge clk);
      play_done = 1'b0;
      check(irq == 1'b1, "R9 irq pulse", {63'd0, irq}, 64'd1);
      if (exp_pend) exp_pend = 1'b0;
      else          exp_play = 1'b0;
      @(negedge clk);
      check(irq == 1'b0, "R9 irq single cycle", {63'd0, irq}, 64'd0);
      check(play_busy == exp_play && ready == !exp_play, "R9 state after done",
            {62'd0, play_busy, ready}, {62'd0, exp_play, !exp_play});
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(play_busy == 0 && ready == 1 && !start_req && !preload_req && !frame_err && !irq,
            "R1 reset state", {58'd0, play_busy, ready, start_req, preload_req, frame_err, irq},
            64'b010000);

      status_ext = 16'hA55C;
      // R3: wrong opcode while idle
      send_frame(mk_frame(8'h81, 8'h00, 11'h123, 11'h456, 5'd0, 8'h00), 56, 1'b0, '0, '0);
      // R7 and R2: valid start
      send_frame(mk_frame(8'h80, 8'h00, 11'h123, 11'h456, 5'd0, 8'h00), 56, 1'b1, 11'h123, 11'h456);
      status_ext = 16'h3C81;
      // R8: valid while playing, wrapped range passed through
      send_frame(mk_frame(8'h80, 8'h00, 11'h7FF, 11'h010, 5'd0, 8'h00), 56, 1'b1, 11'h7FF, 11'h010);
      // R4: filler bit set
      send_frame(mk_frame(8'h80, 8'h00, 11'h001, 11'h002, 5'b00100, 8'h00), 56, 1'b0, '0, '0);
      // R3: second byte nonzero, last byte nonzero
      send_frame(mk_frame(8'h80, 8'h01, 11'h001, 11'h002, 5'd0, 8'h00), 56, 1'b0, '0, '0);
      send_frame(mk_frame(8'h80, 8'h00, 11'h001, 11'h002, 5'd0, 8'h40), 56, 1'b0, '0, '0);
      // R5: one bit short, one byte long
      send_frame(mk_frame(8'h80, 8'h00, 11'h055, 11'h0AA, 5'd0, 8'h00), 55, 1'b0, '0, '0);
      send_frame(mk_frame(8'h80, 8'h00, 11'h055, 11'h0AA, 5'd0, 8'h00), 64, 1'b0, '0, '0);
      // R9: queued segment keeps play, then back to idle
      finish_segment();
      finish_segment();
      // R7 again from idle, edge addresses
      status_ext = 16'hFFFF;
      send_frame(mk_frame(8'h80, 8'h00, 11'h000, 11'h7FF, 5'd0, 8'h00), 56, 1'b1, 11'h000, 11'h7FF);
      finish_segment();
      repeat (10) @(negedge clk);
      check(exp_q.size() == 0, "R10 all expected pulses seen", 64'(exp_q.size()), 64'd0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule